// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a clocked system to an external asynchronous static RAM of 262,144 words by 4 bits. A client hands it one word access at a time over a valid/ready handshake: an 18-bit address, a direction flag and, for writes, a 4-bit data word. The controller turns each request into a fixed sequence of active-low strobes (chip select, output enable, write enable), an address bus and a split tri-state data bus (drive value, drive enable, sampled input).

The length of each phase is set by parameters counted in clock cycles. Each one is the ceiling of the memory's time rule divided by the clock period. For a 10 ns clock and the fastest memory grade, the defaults are two read-wait cycles, two write-pulse cycles and one turnaround cycle. A write always ends when write enable rises. Every access is followed by one hold cycle, in which all strobes are high and the address and write data stay put, and then by the turnaround cycles. Only after that is the next request taken. Read data comes back with a one-cycle response pulse.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, all three strobes are 1, `sram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken at a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 for `WR_PULSE+1+TURN` cycles after a write (`req_write`=1) and for `RD_WAIT+1+TURN` cycles after a read (`req_write`=0). It returns to 1 in the next cycle.
- R3: For a write, `sram_ce_n` and `sram_we_n` are 0 for exactly `WR_PULSE` cycles, starting the cycle after acceptance. `sram_oe_n` stays 1 throughout. Both strobes then rise together.
- R4: During a write pulse and for one cycle after `sram_we_n` rises, `sram_dq_oe` is 1 and `sram_dq_out` equals the accepted write data. In the following cycle `sram_dq_oe` is 0.
- R5: For a read, `sram_ce_n` and `sram_oe_n` are 0 for exactly `RD_WAIT` cycles, starting the cycle after acceptance, and `sram_we_n` stays 1.
- R6: `rsp_rdata` holds the value of `sram_dq_in` sampled in the last read-wait cycle. `rsp_valid` is 1 for exactly one cycle: the cycle in which `sram_oe_n` has just risen.
- R7: `sram_addr` equals the accepted address from the first strobe cycle through the hold cycle. Changes on `req_addr` and `req_wdata` while an access is in progress do not reach the memory pins.
- R8: `sram_dq_oe` is never 1 while `sram_oe_n` is 0. It rises only after `sram_oe_n` has been 1 for at least `TURN` cycles.
- R9: Whenever `req_ready` is 1, chip select, output enable and write enable are all 1 and the data bus is released.
- R10: If `req_valid` stays high across accesses, the next request is taken at the first edge where `req_ready` is 1. Its strobes and address start in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (18) | Word address |
| req_wdata | input | DATA_W (4) | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | DATA_W (4) | Read data |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | ADDR_W (18) | Memory address bus |
| sram_dq_out | output | DATA_W (4) | Value to drive on the data bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | DATA_W (4) | Value sampled from the data bus |

## Verification
Take the accepting edge as edge 0. All strobe and bus outputs are registered, so they change at edge 0 and hold through cycle k until edge k. The write pulse fills cycles 1 to `WR_PULSE` and the read window fills cycles 1 to `RD_WAIT`. The hold cycle, which carries `rsp_valid` on a read, is the one right after that window, and `req_ready` returns in cycle `n+2+TURN`, where n is the pulse or wait length. Each scenario task samples on the falling edge inside every cycle k and compares the pins against this schedule. The bench memory model answers only while a read is legal, so capture in the wrong cycle or a wrong address shows up in the read data.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  // Access sequencer states
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_HOLD = 3'd3,
    ST_TURN = 3'd4
  } acc_state_e;

endpackage

// File: rtl/asram_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module asram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/asram_tick_cnt.sv
// Down counter for phase lengths; last is high while the count is zero.
module asram_tick_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
// Access sequencer: idle -> strobe phase -> hold -> turnaround -> idle.
module asram_seq
  import asram_ctrl_pkg::*;
#(
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 2,
  parameter int TURN     = 1,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             last,
  output acc_state_e       state_q,
  output acc_state_e       state_d,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             accept
);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] TN_LOAD = CNT_W'(TURN - 1);

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cnt_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR;
            cnt_val = WR_LOAD;
          end else begin
            state_d = ST_RD;
            cnt_val = RD_LOAD;
          end
        end
      end
      ST_RD, ST_WR: begin
        if (last) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        state_d  = ST_TURN;
        cnt_load = 1'b1;
        cnt_val  = TN_LOAD;
      end
      ST_TURN: begin
        if (last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/asram_dpath.sv
// Request latches, registered strobes and bus drive, read capture.
module asram_dpath
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  acc_state_e        state_q,
  input  acc_state_e        state_d,
  input  logic              last,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic              ce_n_d, oe_n_d, we_n_d, dq_oe_d;
  logic              ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic              cap_en;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rdata_q;

  // Strobes follow the next state so they are glitch-free register outputs.
  always_comb begin
    ce_n_d  = !((state_d == ST_RD) || (state_d == ST_WR));
    oe_n_d  = !(state_d == ST_RD);
    we_n_d  = !(state_d == ST_WR);
    dq_oe_d = (state_d == ST_WR) || ((state_d == ST_HOLD) && wr_q);
    cap_en  = (state_q == ST_RD) && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= sram_dq_in;
    end
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = dq_oe_q;
  assign sram_ce_n   = ce_n_q;
  assign sram_oe_n   = oe_n_q;
  assign sram_we_n   = we_n_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 4,
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 2,
  parameter int TURN     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int MAX_RW = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
  localparam int MAX_PH = (MAX_RW > TURN) ? MAX_RW : TURN;
  localparam int CNT_W  = (MAX_PH < 2) ? 1 : $clog2(MAX_PH);

  logic             rst_int_n;
  acc_state_e       state_q;
  acc_state_e       state_d;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             last;
  logic             accept;

  asram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  asram_seq #(
    .RD_WAIT  (RD_WAIT),
    .WR_PULSE (WR_PULSE),
    .TURN     (TURN),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .last      (last),
    .state_q   (state_q),
    .state_d   (state_d),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .accept    (accept)
  );

  asram_tick_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (last)
  );

  asram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .accept      (accept),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .state_q     (state_q),
    .state_d     (state_d),
    .last        (last),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .sram_ce_n   (sram_ce_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W   = 18,
  parameter int WR_PULSE = 2,
  parameter int TURN     = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_dq_oe
);
  localparam int WCNT_W = $clog2(WR_PULSE + 2) + 1;
  localparam int TCNT_W = $clog2(TURN + 2) + 1;

  logic [WCNT_W-1:0] we_low_cnt;
  logic [TCNT_W-1:0] oe_high_cnt;

  // Consecutive cycles with write enable low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
    end else if (!sram_we_n) begin
      we_low_cnt <= we_low_cnt + 1'b1;
    end else begin
      we_low_cnt <= '0;
    end
  end

  // Consecutive cycles with output enable high, saturating at TURN.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_high_cnt <= TCNT_W'(TURN);
    end else if (!sram_oe_n) begin
      oe_high_cnt <= '0;
    end else if (oe_high_cnt < TCNT_W'(TURN)) begin
      oe_high_cnt <= oe_high_cnt + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe)); // R9

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt == WCNT_W'(WR_PULSE))); // R3

  AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> $rose(sram_ce_n)); // R3

  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_dq_oe); // R4

  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> !sram_dq_oe); // R4

  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n); // R5

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6

  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(sram_oe_n)); // R6

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce_n) |-> $stable(sram_addr)); // R7

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R8

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_high_cnt >= TCNT_W'(TURN))); // R8
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .WR_PULSE (WR_PULSE),
  .TURN     (TURN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_addr  (sram_addr),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;
  localparam int AW  = 18;
  localparam int DW  = 4;
  localparam int RDW = 2;
  localparam int WRP = 2;
  localparam int TRN = 1;
  localparam int MDEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          sram_ce_n, sram_oe_n, sram_we_n;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq_out;
  logic          sram_dq_oe;
  logic [DW-1:0] sram_dq_in;

  int n_chk = 0;
  int n_err = 0;
  int clash = 0;

  always #2 clk = ~clk;

  asram_ctrl #(
    .ADDR_W (AW), .DATA_W (DW), .RD_WAIT (RDW), .WR_PULSE (WRP), .TURN (TRN)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .sram_ce_n (sram_ce_n), .sram_oe_n (sram_oe_n), .sram_we_n (sram_we_n),
    .sram_addr (sram_addr), .sram_dq_out (sram_dq_out), .sram_dq_oe (sram_dq_oe),
    .sram_dq_in (sram_dq_in)
  );

  // Memory model: small array indexed by low address bits, with a full
  // address tag so that wrong upper bits corrupt the returned data.
  logic [DW-1:0] mem [MDEPTH];
  logic [AW-1:0] tag [MDEPTH];
  logic [DW-1:0] shadow [MDEPTH];
  logic          pend;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] pend_d;

  always_comb begin
    if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
      if (tag[sram_addr[5:0]] == sram_addr) sram_dq_in = mem[sram_addr[5:0]];
      else                                  sram_dq_in = ~mem[sram_addr[5:0]];
    end else begin
      sram_dq_in = 4'hA;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MDEPTH; i++) begin
        mem[i] = DW'(i) ^ 4'h5;
        tag[i] = AW'(i);
      end
      pend = 1'b0;
    end else begin
      if (sram_dq_oe && !sram_oe_n) clash++;
      if (!sram_ce_n && !sram_we_n) begin
        pend   = 1'b1;
        pend_a = sram_addr;
        pend_d = sram_dq_out;
      end else if (pend) begin
        mem[pend_a[5:0]] = pend_d;
        tag[pend_a[5:0]] = pend_a;
        pend = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk({sram_ce_n, sram_oe_n, sram_we_n} == 3'b111, "R1 strobes",
        int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
    chk(sram_dq_oe == 1'b0, "R1 dq_oe", int'(sram_dq_oe), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  // Write; after acceptance the request inputs are scrambled (R7).
  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int k = 1; k <= WRP + TRN + 2; k++) begin
      @(negedge clk);
      if (k <= WRP) begin
        chk(!sram_ce_n && !sram_we_n && sram_oe_n, "R3 pulse",
            int'({sram_ce_n, sram_oe_n, sram_we_n}), 2);
        chk(sram_dq_oe && sram_dq_out == d, "R4 drive", int'(sram_dq_out), int'(d));
        chk(sram_addr == a, "R7 addr", int'(sram_addr), int'(a));
        chk(!req_ready, "R2 busy", int'(req_ready), 0);
      end else if (k == WRP + 1) begin
        chk(sram_ce_n && sram_we_n && sram_oe_n, "R3 end",
            int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
        chk(sram_dq_oe && sram_dq_out == d, "R4 hold", int'(sram_dq_out), int'(d));
        chk(sram_addr == a, "R7 hold addr", int'(sram_addr), int'(a));
      end else if (k <= WRP + TRN + 1) begin
        chk(!sram_dq_oe, "R4 release", int'(sram_dq_oe), 0);
        chk(!req_ready, "R2 turn", int'(req_ready), 0);
      end else begin
        chk(req_ready, "R2 ready back", int'(req_ready), 1);
      end
      if (k == 1) begin
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      end
    end
    shadow[a[5:0]] = d;
  endtask

  task automatic t_read(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    for (int k = 1; k <= RDW + TRN + 2; k++) begin
      @(negedge clk);
      if (k <= RDW) begin
        chk(!sram_ce_n && !sram_oe_n && sram_we_n, "R5 strobes",
            int'({sram_ce_n, sram_oe_n, sram_we_n}), 1);
        chk(!sram_dq_oe, "R8 no drive", int'(sram_dq_oe), 0);
        chk(!rsp_valid, "R6 early", int'(rsp_valid), 0);
        chk(sram_addr == a, "R7 addr", int'(sram_addr), int'(a));
      end else if (k == RDW + 1) begin
        chk(sram_oe_n && sram_ce_n, "R5 end", int'(sram_oe_n), 1);
        chk(rsp_valid, "R6 valid", int'(rsp_valid), 1);
        chk(rsp_rdata == shadow[a[5:0]], "R6 data", int'(rsp_rdata), int'(shadow[a[5:0]]));
      end else if (k == RDW + 2) begin
        chk(!rsp_valid, "R6 pulse", int'(rsp_valid), 0);
        chk(!req_ready, "R2 turn", int'(req_ready), 0);
      end else begin
        chk(req_ready, "R2 ready back", int'(req_ready), 1);
      end
      if (k == 1) req_valid = 1'b0;
    end
  endtask

  // Write then read with req_valid held high throughout (R10, R7).
  task automatic t_b2b(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [AW-1:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int k = 1; k <= WRP + TRN + 2; k++) begin
      @(negedge clk);
      if (k <= WRP + 1)
        chk(sram_addr == a, "R7 addr while valid", int'(sram_addr), int'(a));
      if (k == 1) begin req_write = 1'b0; req_addr = b; end
    end
    shadow[a[5:0]] = d;
    @(posedge clk);
    @(negedge clk);
    chk(!sram_ce_n && !sram_oe_n, "R10 read starts", int'(sram_oe_n), 0);
    chk(sram_addr == b, "R10 addr", int'(sram_addr), int'(b));
    req_valid = 1'b0;
    for (int k = 2; k <= RDW + 1; k++) @(negedge clk);
    chk(rsp_valid && rsp_rdata == shadow[b[5:0]], "R10 data",
        int'(rsp_rdata), int'(shadow[b[5:0]]));
    for (int k = RDW + 2; k <= RDW + TRN + 2; k++) @(negedge clk);
    chk(req_ready, "R10 ready", int'(req_ready), 1);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < MDEPTH; i++) shadow[i] = DW'(i) ^ 4'h5;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read(18'h00007);
    t_write(18'h00003, 4'h9);
    t_read(18'h00003);
    t_write(18'h2A5C3, 4'h6);
    t_read(18'h2A5C3);
    t_write(18'h3FFFF, 4'hF);
    t_write(18'h00000, 4'h0);
    t_read(18'h3FFFF);
    t_read(18'h00000);
    t_b2b(18'h1F011, 4'hC, 18'h1F011);
    t_b2b(18'h00022, 4'h3, 18'h2A5C3);
    repeat (2) @(negedge clk);
    chk(clash == 0, "R8 contention", clash, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule